// File: doc/BRIEF.md
# Manchester Frame Receiver

This block recovers a fixed-length data word from a single serial line that carries Manchester-coded bits. The receive clock runs at exactly twice the bit rate, so each bit period gives two line samples, one per half. A bit is valid only if the line changes level in the middle of the bit. A rise from low to high (samples 0 then 1) decodes as 1. A fall from high to low (samples 1 then 0) decodes as 0.

A frame starts with a header of `HDR_LEN` bit periods in which both halves are high. The data bits follow straight after the header, with no stop bit, and the frame ends once `DATA_W` bits have arrived. When the line is idle it is held low. The first high sample after a low idle line sets the half-bit phase.

The block has three states: idle, decode and error. In idle it looks for the header. In decode it shifts bits into a register, with the first bit received going to the most significant position. When a complete word has arrived it updates the output and pulses a valid strobe for one clock. If the two halves of a bit are equal, there was no mid-bit transition. The block then pulses an error flag, leaves the output word as it was, and returns to idle one clock later.

Top module: `manch_frame_rx`

## Requirements
- R1: After a synchronous active-high reset, `word_o` is all zeros and `valid_o` and `err_o` are low.
- R2: A header shorter than `HDR_LEN` high bit periods is not accepted. Bits that follow such a header produce no `valid_o` and leave `word_o` unchanged.
- R3: A header longer than `HDR_LEN` high bit periods is accepted. The first bit period that is not high-high is the first data bit.
- R4: A bit period sampled as (0,1) decodes as 1, and a bit period sampled as (1,0) decodes as 0.
- R5: The first data bit lands in bit `DATA_W-1` of `word_o`. `word_o` is updated, and `valid_o` is high, in the clock that follows the edge on which the second half of the last data bit is sampled.
- R6: `valid_o` lasts exactly one clock. `word_o` does not change in any cycle in which `valid_o` is low.
- R7: A data bit sampled as (0,0) or (1,1) raises `err_o` for exactly one clock, raises no `valid_o` and leaves `word_o` unchanged. This also applies to the first bit after the header.
- R8: After an error, the receiver is back in idle one clock later, and it decodes the next well-formed frame correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, two cycles per bit period |
| rst | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Manchester-coded serial line, sampled on each rising edge |
| word_o | output | DATA_W | Last word received without error, first bit in the MSB |
| valid_o | output | 1 | One-clock strobe that marks an update of word_o |
| err_o | output | 1 | One-clock strobe that marks a bit with no mid-bit transition |

## Verification
The bench builds the receiver with its default parameters, a 28-bit word and a four-period header. This setting covers the full frame length, a header that is exactly as long as required, headers that are one period too short or three periods too long, and data that begins with a 0 bit, whose high first half extends the header run. Errors are placed on the first bit and in the middle of a frame, both with two low halves and with two high halves. Each error is followed by a clean frame, which shows that the receiver recovers.

// File: rtl/manch_frame_rx.sv
module manch_frame_rx #(
  parameter int DATA_W  = 28,
  parameter int HDR_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam int HW = $clog2(HDR_LEN + 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_DEC = 2'd1, S_ERR = 2'd2} st_t;

  st_t              state_q;
  logic             phase_q;
  logic             first_q;
  logic [HW-1:0]    hcnt_q;
  logic [CW-1:0]    bcnt_q;
  logic [DATA_W-1:0] shr_q;

  wire              hdr_full = (hcnt_q == HW'(HDR_LEN));
  wire              pair_ok  = first_q ^ line_i;
  wire [DATA_W-1:0] shr_nx   = {shr_q[DATA_W-2:0], line_i};
  wire              last_bit = (bcnt_q == CW'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      phase_q <= 1'b0;
      first_q <= 1'b0;
      hcnt_q  <= '0;
      bcnt_q  <= '0;
      shr_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (!phase_q) begin
            first_q <= line_i;
            if (line_i || hcnt_q != '0) phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            if (first_q && line_i) begin
              if (!hdr_full) hcnt_q <= hcnt_q + 1'b1;
            end else if (hdr_full) begin
              hcnt_q <= '0;
              if (pair_ok) begin
                shr_q   <= shr_nx;
                bcnt_q  <= CW'(1);
                state_q <= S_DEC;
              end else begin
                err_o   <= 1'b1;
                state_q <= S_ERR;
              end
            end else begin
              hcnt_q <= '0;
            end
          end
        end
        S_DEC: begin
          if (!phase_q) begin
            first_q <= line_i;
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            if (pair_ok) begin
              shr_q  <= shr_nx;
              bcnt_q <= bcnt_q + 1'b1;
              if (last_bit) begin
                word_o  <= shr_nx;
                valid_o <= 1'b1;
                bcnt_q  <= '0;
                state_q <= S_IDLE;
              end
            end else begin
              err_o   <= 1'b1;
              bcnt_q  <= '0;
              state_q <= S_ERR;
            end
          end
        end
        default: begin
          phase_q <= 1'b0;
          hcnt_q  <= '0;
          bcnt_q  <= '0;
          state_q <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module manch_frame_rx_chk #(
  parameter int DATA_W = 28,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        state,
  input logic [CW-1:0]     bcnt,
  input logic [DATA_W-1:0] word,
  input logic              valid,
  input logic              err
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst) valid |=> !valid); // R6
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst) !valid |-> $stable(word)); // R6
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst) err |=> !err); // R7
  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (rst) !(err && valid)); // R7
  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst) err |=> state == 2'd0); // R8
  AST_VALID_FROM_DEC: assert property (@(posedge clk) disable iff (rst) valid |-> $past(state) == 2'd1); // R5
  AST_BCNT_RANGE: assert property (@(posedge clk) disable iff (rst) bcnt < CW'(DATA_W)); // R5
endmodule

bind manch_frame_rx manch_frame_rx_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .state(state_q), .bcnt(bcnt_q),
  .word(word_o), .valid(valid_o), .err(err_o)
);

// File: tb/manch_frame_rx_bench.sv
module manch_frame_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 28;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_i = 1'b0;
  logic [W-1:0] word_o;
  logic valid_o, err_o;
  int checks = 0, fails = 0, vcount = 0, ecount = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  manch_frame_rx #(.DATA_W(W), .HDR_LEN(H)) u_manch_frame_rx (
    .clk(clk), .rst(rst), .line_i(line_i),
    .word_o(word_o), .valid_o(valid_o), .err_o(err_o));

  always @(negedge clk) begin
    if (valid_o) vcount++;
    if (err_o) ecount++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    @(negedge clk);
    line_i = v;
  endtask

  task automatic idle_low(input int n);
    for (int i = 0; i < n; i++) drive(1'b0);
  endtask

  task automatic send_hdr(input int n);
    for (int i = 0; i < 2 * n; i++) drive(1'b1);
  endtask

  task automatic send_bits(input logic [W-1:0] d, input int nbits);
    for (int i = W - 1; i >= W - nbits; i--) begin
      drive(~d[i]);
      drive(d[i]);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 word", word_o, '0);
    chk("R1 valid", valid_o, 0);
    chk("R1 err", err_o, 0);
    rst = 1'b0;
    idle_low(4);
  endtask

  task automatic t_frame(input int hdr, input logic [W-1:0] d, input string req);
    send_hdr(hdr);
    send_bits(d, W);
    drive(1'b0);
    chk({req, " valid"}, valid_o, 1);
    chk({req, " word"}, word_o, d);
    drive(1'b0);
    chk("R6 valid one clock", valid_o, 0);
    chk("R6 word held", word_o, d);
    idle_low(4);
  endtask

  task automatic t_short_hdr(input logic [W-1:0] d);
    logic [W-1:0] w0 = word_o;
    int v0 = vcount;
    send_hdr(H - 1);
    send_bits(d, W);
    idle_low(8);
    chk("R2 no valid", vcount - v0, 0);
    chk("R2 word unchanged", word_o, w0);
  endtask

  task automatic t_error(input int nbits, input logic [W-1:0] d, input logic bad, input string req);
    logic [W-1:0] w0 = word_o;
    int v0 = vcount, e0 = ecount;
    send_hdr(H);
    send_bits(d, nbits);
    drive(bad);
    drive(bad);
    drive(1'b0);
    chk({req, " err"}, err_o, 1);
    drive(1'b0);
    chk("R7 err one clock", err_o, 0);
    idle_low(6);
    chk("R7 one err", ecount - e0, 1);
    chk("R7 no valid", vcount - v0, 0);
    chk("R7 word unchanged", word_o, w0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame(H, 28'hA5C396E, "R4 R5 mixed");
    t_frame(H, 28'hFFFFFFF, "R4 ones");
    t_frame(H, 28'h0000000, "R4 zeros");
    t_frame(H + 3, 28'h0123456, "R3 long header");
    t_frame(H, 28'h8000001, "R5 msb first");
    t_short_hdr(28'h5A5A5A5);
    idle_low(20);
    chk("R6 word held over gap", word_o, 28'h8000001);
    t_error(10, 28'h3C3C3C3, 1'b0, "R7 low pair");
    t_frame(H, 28'h7654321, "R8 recover");
    t_error(17, 28'hF0F0F0F, 1'b1, "R7 high pair");
    t_error(0, 28'h0, 1'b0, "R7 first bit");
    t_frame(H + 1, 28'hBADCAFE, "R8 recover again");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule